// File: doc/BRIEF.md
# Multi-Mode Prescaled Timer/Counter

This block is a 16-bit up/down counter that can advance from three clock sources. In timer mode it advances once per prescaler period, and the prescaler period is a power-of-two number of system clocks. In gated mode it advances on the same prescaler ticks, but only while a synchronised external pin is at its active level. That makes it suitable for pulse-width or duty-cycle measurement. In counter mode it advances on selected edges of the same synchronised pin. Wrapping past the end of the count range produces a one-clock overflow or underflow strobe.

The mode logic is a four-state machine:
- `ST_STOP`: the count holds and the prescaler is cleared.
- `ST_TIMER`: the count advances on prescaler ticks.
- `ST_GATED`: the count advances on prescaler ticks while the gate is active.
- `ST_COUNT`: the count advances on pin events.

Each clock, the machine moves to the state named by `mode_sel` while `run` is high. It moves to `ST_STOP` when `run` is low or when `mode_sel` is the hold code. Every state can reach every other state in one clock.

Top module: `multimode_timer`

## Requirements
- R1: After reset, `count` is 0x0000 and both `ovf` and `unf` are low.
- R2: The prescaler ratio is 8 << `psc_sel`, from 8 for code 000 up to 1024 for code 111. In timer mode (`mode_sel`=00) the count advances once every ratio clocks.
- R3: The state machine follows `run` one clock later. The prescaler starts from zero in its first active clock, so the first advance comes ratio clocks after that.
- R4: While the machine is in `ST_STOP`, the count holds its value and the prescaler is held at zero.
- R5: In gated mode (`mode_sel`=01), prescaler ticks advance the count only while the synchronised pin equals NOT `gate_pol`. That is, `gate_pol`=0 gives an active-high gate and `gate_pol`=1 gives an active-low gate. The prescaler keeps running while the gate is closed.
- R6: In counter mode (`mode_sel`=10), the pin passes through two flip-flops and is then compared with its previous synchronised value. `edge_sel`=00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both. Each qualifying edge advances the count once.
- R7: `count_down`=0 counts up and `count_down`=1 counts down. Each advance changes the count by exactly one.
- R8: An up-count from 0xFFFF to 0x0000 raises `ovf` for exactly the one clock in which the count reads 0x0000.
- R9: A down-count from 0x0000 to 0xFFFF raises `unf` for exactly the one clock in which the count reads 0xFFFF.
- R10: `mode_sel`=11 is a hold code. With `run` high, it puts the machine in `ST_STOP`, so the count holds and the prescaler clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_sel | input | 3 | Prescaler code; ratio is 8 << code |
| mode_sel | input | 2 | 00 timer, 01 gated, 10 counter, 11 hold |
| edge_sel | input | 2 | Counter-mode edge: 00 rising, 01 falling, 1x both |
| gate_pol | input | 1 | 0 = gate active high, 1 = gate active low |
| count_down | input | 1 | 1 = count down, 0 = count up |
| run | input | 1 | Enables counting |
| ext_pin | input | 1 | External gate or event input (asynchronous) |
| count | output | 16 | Current count value |
| ovf | output | 1 | One-clock strobe on up-wrap |
| unf | output | 1 | One-clock strobe on down-wrap |

## Verification
The embedded properties assume three things:
- reset is asserted from time zero;
- every control input changes only between clock edges;
- the pin is the only asynchronous input.

The stimulus drives every control on the falling clock edge. In counter mode it holds each pin level for at least two clocks, so every edge passes the synchroniser and is counted exactly once. Wrap strobes are reached by counting down through zero and then back up through 0xFFFF, which needs only a few hundred advances.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic [1:0] {
        ST_STOP  = 2'b00,
        ST_TIMER = 2'b01,
        ST_GATED = 2'b10,
        ST_COUNT = 2'b11
    } tmr_state_e;

    localparam logic [1:0] MODE_TIMER = 2'b00;
    localparam logic [1:0] MODE_GATED = 2'b01;
    localparam logic [1:0] MODE_COUNT = 2'b10;
    localparam logic [1:0] MODE_HOLD  = 2'b11;

    localparam logic [1:0] EDGE_RISE = 2'b00;
    localparam logic [1:0] EDGE_FALL = 2'b01;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SEL_W   = 3,
    parameter int MIN_LOG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PSC_W = MIN_LOG + (1 << SEL_W) - 1;

    logic [PSC_W-1:0] div_q;
    logic [PSC_W:0]   limit;

    assign limit = ({{PSC_W{1'b0}}, 1'b1} << (MIN_LOG + int'(sel))) - 1'b1;
    assign tick  = enable && ({1'b0, div_q} >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (!enable || tick)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    // R2: the smallest ratio is 8, so two ticks never come back to back
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R4: a stopped prescaler restarts from zero
    p_clear_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (div_q == '0));
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] edge_sel,
    output logic       level,
    output logic       event_o
);
    import timer_pkg::*;

    logic meta_q, sync_q, prev_q;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;
    assign fall  = ~sync_q & prev_q;

    always_comb begin
        unique case (edge_sel)
            EDGE_RISE: event_o = rise;
            EDGE_FALL: event_o = fall;
            default:   event_o = rise | fall;
        endcase
    end

    // R6: an event always marks a change of the synchronised level
    p_event_is_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> (level != prev_q));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       mode,
    input  logic             tick,
    input  logic             gate_lvl,
    input  logic             gate_pol,
    input  logic             pin_event,
    input  logic             count_down,
    output logic             active,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             unf
);
    import timer_pkg::*;

    tmr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q, unf_q, adv;

    always_comb begin
        st_d = ST_STOP;
        if (run) begin
            unique case (mode)
                MODE_TIMER: st_d = ST_TIMER;
                MODE_GATED: st_d = ST_GATED;
                MODE_COUNT: st_d = ST_COUNT;
                MODE_HOLD:  st_d = ST_STOP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STOP;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_STOP:  adv = 1'b0;
            ST_TIMER: adv = tick;
            ST_GATED: adv = tick && (gate_lvl ^ gate_pol);
            ST_COUNT: adv = pin_event;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            if (adv) begin
                if (count_down) begin
                    cnt_q <= cnt_q - 1'b1;
                    unf_q <= (cnt_q == '0);
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    ovf_q <= &cnt_q;
                end
            end
        end
    end

    assign active = (st_q != ST_STOP);
    assign count  = cnt_q;
    assign ovf    = ovf_q;
    assign unf    = unf_q;

    // R4 / R10: stopped machine keeps the count
    p_hold_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP) |=> $stable(cnt_q));
    // R7: each change is a single step
    p_unit_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1)));
    // R8: overflow only right after an up-wrap
    p_ovf_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> ((cnt_q == '0) && ($past(cnt_q) == '1)));
    // R9: underflow only right after a down-wrap
    p_unf_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |-> ((cnt_q == '1) && ($past(cnt_q) == '0)));
    // R8 / R9: strobes never coincide
    p_no_dual_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_q && unf_q));
endmodule

// File: rtl/multimode_timer.sv
module multimode_timer #(
    parameter int CNT_W   = 16,
    parameter int SEL_W   = 3,
    parameter int MIN_LOG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] psc_sel,
    input  logic [1:0]       mode_sel,
    input  logic [1:0]       edge_sel,
    input  logic             gate_pol,
    input  logic             count_down,
    input  logic             run,
    input  logic             ext_pin,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             unf
);
    logic active, tick, pin_lvl, pin_evt;

    tmr_prescaler #(.SEL_W(SEL_W), .MIN_LOG(MIN_LOG)) i_psc (
        .clk(clk), .rst_n(rst_n), .enable(active), .sel(psc_sel), .tick(tick)
    );

    tmr_pin_sync i_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .edge_sel(edge_sel),
        .level(pin_lvl), .event_o(pin_evt)
    );

    tmr_core #(.CNT_W(CNT_W)) i_core (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode_sel), .tick(tick),
        .gate_lvl(pin_lvl), .gate_pol(gate_pol), .pin_event(pin_evt),
        .count_down(count_down), .active(active), .count(count),
        .ovf(ovf), .unf(unf)
    );
endmodule

// File: tb/test_multimode_timer.sv
module test_multimode_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  psc_sel = 3'd0;
    logic [1:0]  mode_sel = 2'b00;
    logic [1:0]  edge_sel = 2'b00;
    logic        gate_pol = 1'b0;
    logic        count_down = 1'b0;
    logic        run = 1'b0;
    logic        ext_pin = 1'b0;
    logic [15:0] count;
    logic        ovf, unf;

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    int    ovf_seen = 0;
    int    unf_seen = 0;
    string tag = "R1";

    // behavioural reference state
    int          m_st = 0;   // 0 stop, 1 timer, 2 gated, 3 counter
    int          m_div = 0;
    logic [15:0] m_cnt = 16'h0;
    logic        m_ovf = 1'b0, m_unf = 1'b0;
    logic        m_p1 = 1'b0, m_p2 = 1'b0, m_p3 = 1'b0;

    always #10 clk = ~clk;

    multimode_timer i_multimode_timer (
        .clk(clk), .rst_n(rst_n), .psc_sel(psc_sel), .mode_sel(mode_sel),
        .edge_sel(edge_sel), .gate_pol(gate_pol), .count_down(count_down),
        .run(run), .ext_pin(ext_pin), .count(count), .ovf(ovf), .unf(unf)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_div = 0; m_cnt = 16'h0; m_ovf = 0; m_unf = 0;
            m_p1 = 0; m_p2 = 0; m_p3 = 0;
        end else begin
            int  ratio;
            bit  tick, ev, adv;
            ratio = 8 * (1 << psc_sel);
            tick  = (m_st != 0) && (m_div >= ratio - 1);
            case (edge_sel)
                2'b00:   ev = m_p2 && !m_p3;
                2'b01:   ev = !m_p2 && m_p3;
                default: ev = m_p2 != m_p3;
            endcase
            case (m_st)
                1:       adv = tick;
                2:       adv = tick && (m_p2 != gate_pol);
                3:       adv = ev;
                default: adv = 0;
            endcase
            m_div = (m_st == 0 || tick) ? 0 : m_div + 1;
            m_ovf = 0; m_unf = 0;
            if (adv) begin
                if (count_down) begin m_unf = (m_cnt == 16'h0000); m_cnt = m_cnt - 1; end
                else            begin m_ovf = (m_cnt == 16'hFFFF); m_cnt = m_cnt + 1; end
            end
            if (!run || mode_sel == 2'b11) m_st = 0;
            else                           m_st = mode_sel + 1;
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = ext_pin;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            checks++;
            if (count !== m_cnt || ovf !== m_ovf || unf !== m_unf) begin
                errors++;
                $display("FAIL %s cycle %0d: count=%h ovf=%b unf=%b expected count=%h ovf=%b unf=%b",
                         tag, cyc, count, ovf, unf, m_cnt, m_ovf, m_unf);
            end
            if (ovf) ovf_seen++;
            if (unf) unf_seen++;
        end
        if (cyc == 190000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle(input int n, input int hold);
        for (int i = 0; i < n; i++) begin
            ext_pin = ~ext_pin;
            step(hold);
        end
    endtask

    initial begin
        step(4);
        // R1: reset state
        checks++;
        if (count !== 16'h0 || ovf !== 1'b0 || unf !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: count=%h ovf=%b unf=%b expected 0000 0 0", count, ovf, unf);
        end
        rst_n = 1'b1;
        step(3);

        tag = "R3"; run = 1; mode_sel = 2'b00; psc_sel = 3'd0; step(40);
        tag = "R2"; psc_sel = 3'd2; step(300);
        psc_sel = 3'd7; step(2500);
        psc_sel = 3'd1; step(100);
        tag = "R4"; run = 0; toggle(10, 3); step(20);
        tag = "R3"; run = 1; psc_sel = 3'd3; step(200);
        tag = "R10"; mode_sel = 2'b11; step(50); mode_sel = 2'b00; step(130);

        tag = "R5"; mode_sel = 2'b01; psc_sel = 3'd0; gate_pol = 0; ext_pin = 0;
        step(60); ext_pin = 1; step(90); ext_pin = 0; step(70);
        gate_pol = 1; step(90); ext_pin = 1; step(60);

        tag = "R6"; mode_sel = 2'b10; edge_sel = 2'b00; toggle(20, 3);
        edge_sel = 2'b01; toggle(20, 2);
        edge_sel = 2'b10; toggle(20, 4);
        edge_sel = 2'b11; toggle(10, 2);

        tag = "R7"; count_down = 1; edge_sel = 2'b10; toggle(16, 3);
        tag = "R9";
        while (m_cnt != 16'h0000 && cyc < 150000) toggle(1, 2);
        toggle(6, 2);
        step(4);
        checks++;
        if (unf_seen != 1) begin
            errors++;
            $display("FAIL R9 underflow strobes: got %0d expected 1", unf_seen);
        end
        tag = "R8"; count_down = 0; toggle(14, 2); step(4);
        checks++;
        if (ovf_seen != 1) begin
            errors++;
            $display("FAIL R8 overflow strobes: got %0d expected 1", ovf_seen);
        end
        tag = "R4"; run = 0; toggle(6, 3); step(10);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule